// File: doc/BRIEF.md
# Banked SRAM Controller With Wait States

This block drives an external static memory on behalf of an internal requester. Each request carries a 16-bit word address, 16 bits of write data and a read/write flag. The controller turns it into one bus cycle on a 16-bit address bus and a 16-bit data bus. The cycle uses active-low output-enable and write-enable strobes, plus one of four active-low chip selects.

The address space is split into four banks by four 8-bit limit values, each counted in pages of 1024 words. The chip select is chosen by comparing the page number of the address with these limits. Every access can be lengthened by 0 to 7 wait cycles, to suit slow parts. When the access finishes, a one-cycle `done` pulse is raised. For a read, the captured data comes with it. For an address that no bank claims, an error flag comes with it.

Only one bus cycle runs at a time. A request that arrives while the bus is busy is held in a single slot. It starts on the cycle after the current access ends.

Top module: `banked_sram_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, all chip selects, `mem_oe_n` and `mem_we_n` are high, `done` is low, `mem_dout_en` is low and `mem_dout` is zero.
- R2: The page number is address bits [15:10]. Bank limit i is `bank_limits[8*i+7:8*i]` and is an exclusive upper page bound. The access asserts `mem_cs_n[i]` for the lowest i whose limit is greater than the page. A bank whose limit does not exceed the limit of a lower bank never gets selected.
- R3: An address whose page is not below any limit asserts no chip select and no strobe. It still completes after the normal duration, with `err` high alongside `done`; it leaves memory unchanged.
- R4: `wait_cfg` is sampled when an access starts. The selected chip select stays low for exactly 2 + `wait_cfg` consecutive cycles.
- R5: The first cycle of an access has both strobes high. The strobe stays low for the remaining 1 + `wait_cfg` cycles: `mem_oe_n` for reads, `mem_we_n` for writes. The two strobes are never low together.
- R6: `mem_dout_en` is high exactly while `mem_we_n` is low, and `mem_dout` then carries the request's write data. Otherwise `mem_dout` is zero.
- R7: `mem_din` is captured on the last cycle of a read. In the cycle after the access ends, `done` is high for one cycle, and `rd_data` shows the captured word.
- R8: A request made while an access is in progress is held. It starts in the cycle after the current access ends, and its `done` follows in order.
- R9: At most one chip select is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| bank_limits | input | 32 | Four 8-bit exclusive page limits, bank 0 in the low byte |
| wait_cfg | input | 3 | Wait cycles added to each access |
| done | output | 1 | Access complete pulse |
| err | output | 1 | Address matched no bank (valid with done) |
| rd_data | output | 16 | Word captured by the last read |
| mem_addr | output | 16 | Memory address bus |
| mem_dout | output | 16 | Write data toward memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Read data from memory |
| mem_cs_n | output | 4 | Active-low bank selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume that the requester never sends a new request while one is already held and the bus is still busy, since the single hold slot would otherwise be overwritten. The stimulus respects this. It waits until the expected-result queue is empty before each new request, and only in the back-to-back case does it send exactly one extra request during an access. Bank limits and the wait count are changed only while the bus is idle, so every access sees a stable configuration from start to finish.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_req_t;
endpackage

// File: rtl/bsram_bank_decode.sv
module bsram_bank_decode #(
    parameter int NBANK   = 4,
    parameter int LIMIT_W = 8,
    parameter int PAGE_W  = 6
) (
    input  logic [PAGE_W-1:0]        page,
    input  logic [NBANK*LIMIT_W-1:0] limits,
    output logic [NBANK-1:0]         sel,
    output logic                     miss
);
    localparam int CMP_W = (PAGE_W > LIMIT_W) ? PAGE_W : LIMIT_W;

    logic [NBANK-1:0] hit;
    logic [NBANK:0]   claimed;

    assign claimed[0] = 1'b0;

    // Priority chain: the lowest bank whose limit is above the page wins (R2)
    generate
        for (genvar i = 0; i < NBANK; i++) begin : g_bank
            assign hit[i]       = CMP_W'(page) < CMP_W'(limits[i*LIMIT_W +: LIMIT_W]);
            assign sel[i]       = hit[i] & ~claimed[i];
            assign claimed[i+1] = claimed[i] | hit[i];
        end
    endgenerate

    assign miss = ~claimed[NBANK];
endmodule

// File: rtl/bsram_req_hold.sv
module bsram_req_hold
    import bsram_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  mem_req_t in_req,
    input  logic     take,
    output logic     out_valid,
    output mem_req_t out_req
);
    typedef struct packed {
        logic     valid;
        mem_req_t req;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        out_valid = in_valid | h_q.valid;
        out_req   = h_q.valid ? h_q.req : in_req;
        if (h_q.valid) begin
            if (take) begin
                h_d.valid = in_valid;
                h_d.req   = in_req;
            end
        end else if (in_valid && !take) begin
            h_d.valid = 1'b1;
            h_d.req   = in_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    // R8: the requester never overruns the single hold slot
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.valid && !take) |-> !in_valid);

    // R8: a request that cannot start now is still offered next cycle
    a_r8_held_offered: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !take) |=> out_valid);
endmodule

// File: rtl/bsram_access_seq.sv
module bsram_access_seq
    import bsram_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  mem_req_t          start_req,
    input  logic [NBANK-1:0]  start_sel,
    input  logic              start_miss,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              take,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic [NBANK-1:0]  mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = WAIT_W + 1;

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  last;
        logic [NBANK-1:0]  sel;
        logic              miss;
        mem_req_t          req;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;
    logic finishing;
    logic strobe_on;

    assign finishing = s_q.active && (s_q.cnt == s_q.last);
    assign take      = !s_q.active || finishing;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.active) begin
            if (finishing) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
                s_d.err    = s_q.miss;
                if (!s_q.req.write && !s_q.miss) s_d.rdata = mem_din;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
        if (take && start_valid) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.last   = CNT_W'(wait_cfg) + CNT_W'(1);
            s_d.sel    = start_sel;
            s_d.miss   = start_miss;
            s_d.req    = start_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign strobe_on   = s_q.active && !s_q.miss && (s_q.cnt != '0);
    assign mem_cs_n    = (s_q.active && !s_q.miss) ? ~s_q.sel : '1;
    assign mem_we_n    = !(strobe_on && s_q.req.write);
    assign mem_oe_n    = !(strobe_on && !s_q.req.write);
    assign mem_dout_en = strobe_on && s_q.req.write;
    assign mem_dout    = mem_dout_en ? s_q.req.wdata : '0;
    assign mem_addr    = s_q.active ? s_q.req.addr : '0;
    assign done        = s_q.done;
    assign err         = s_q.err;
    assign rd_data     = s_q.rdata;

    // R5: a strobe only falls after a setup cycle with the same select already low
    a_r5_setup_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n & mem_we_n) |-> ($past(mem_cs_n) != '1) && $stable(mem_cs_n));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: an unclaimed address never touches the bus
    a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.miss) |-> (mem_cs_n == '1) && mem_we_n && mem_oe_n);

    // R4: a select stays put until the access finishes
    a_r4_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != '1 && !finishing) |=> $stable(mem_cs_n));
endmodule

// File: rtl/banked_sram_ctrl.sv
module banked_sram_ctrl
    import bsram_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int LIMIT_W  = 8,
    parameter int PAGE_LSB = 10,
    parameter int WAIT_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [NBANK*LIMIT_W-1:0] bank_limits,
    input  logic [WAIT_W-1:0]        wait_cfg,
    output logic                     done,
    output logic                     err,
    output logic [DATA_W-1:0]        rd_data,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_dout,
    output logic                     mem_dout_en,
    input  logic [DATA_W-1:0]        mem_din,
    output logic [NBANK-1:0]         mem_cs_n,
    output logic                     mem_oe_n,
    output logic                     mem_we_n
);
    localparam int PAGE_W = ADDR_W - PAGE_LSB;

    mem_req_t         in_req;
    mem_req_t         cur_req;
    logic             cur_valid;
    logic             take;
    logic [NBANK-1:0] cur_sel;
    logic             cur_miss;

    assign in_req = '{write: req_write, addr: req_addr, wdata: req_wdata};

    bsram_req_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_req    (in_req),
        .take      (take),
        .out_valid (cur_valid),
        .out_req   (cur_req)
    );

    bsram_bank_decode #(
        .NBANK   (NBANK),
        .LIMIT_W (LIMIT_W),
        .PAGE_W  (PAGE_W)
    ) u_decode (
        .page   (cur_req.addr[ADDR_W-1:PAGE_LSB]),
        .limits (bank_limits),
        .sel    (cur_sel),
        .miss   (cur_miss)
    );

    bsram_access_seq #(
        .NBANK  (NBANK),
        .WAIT_W (WAIT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (cur_valid),
        .start_req   (cur_req),
        .start_sel   (cur_sel),
        .start_miss  (cur_miss),
        .wait_cfg    (wait_cfg),
        .take        (take),
        .mem_din     (mem_din),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en),
        .mem_cs_n    (mem_cs_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .done        (done),
        .err         (err),
        .rd_data     (rd_data)
    );

    // R9: never more than one bank selected
    a_r9_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R6: data bus driven exactly while the write strobe is low
    a_r6_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en == !mem_we_n);

    // R5: read and write strobes are exclusive
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // R2: a low strobe always has a bank selected
    a_r2_strobe_has_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (mem_cs_n != '1));
endmodule

// File: tb/tb_banked_sram_ctrl.sv
`timescale 1ns/1ps
module tb_banked_sram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [31:0] bank_limits = {8'd12, 8'd9, 8'd5, 8'd2};
    logic [2:0]  wait_cfg = '0;
    logic        done, err, mem_dout_en, mem_oe_n, mem_we_n;
    logic [15:0] rd_data, mem_addr, mem_dout, mem_din;
    logic [3:0]  mem_cs_n;

    always #4 clk = ~clk;

    banked_sram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .bank_limits(bank_limits),
        .wait_cfg(wait_cfg), .done(done), .err(err), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    typedef struct {
        logic        write;
        logic        err;
        logic [3:0]  cs;
        int          waits;
        logic [15:0] rdata;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] mem     [0:1023];
    logic [15:0] exp_mem [0:1023];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cs_cnt  = 0;
    int          stb_cnt = 0;
    logic [3:0]  cs_seen = 4'hF;
    bit          ended   = 1'b0;

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 16'(i) ^ 16'h5A5A;
            exp_mem[i] = 16'(i) ^ 16'h5A5A;
        end
    end

    always @* mem_din = mem[mem_addr[9:0]];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int bank_of(input logic [15:0] a);
        for (int b = 0; b < 4; b++)
            if ({2'b00, a[15:10]} < bank_limits[8*b +: 8]) return b;
        return -1;
    endfunction

    // Driver: one request, expectation pushed into the scoreboard
    task automatic send(input logic w, input logic [15:0] a, input logic [15:0] d);
        exp_t e;
        int   b;
        b       = bank_of(a);
        e.write = w;
        e.err   = (b < 0);
        e.cs    = (b < 0) ? 4'hF : ~(4'b0001 << b);
        e.waits = int'(wait_cfg);
        e.rdata = exp_mem[a[9:0]];
        if (w && b >= 0) exp_mem[a[9:0]] = d;
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic one(input logic w, input logic [15:0] a, input logic [15:0] d, input int waits);
        wait_cfg = 3'(waits);
        send(w, a, d);
        drain();
    endtask

    // Monitor: per-cycle bus observation and in-order comparison on done
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(err == e.err, "R3 err flag", 32'(err), 32'(e.err));
                    chk(cs_seen == e.cs, "R2 chip select", 32'(cs_seen), 32'(e.cs));
                    chk(cs_cnt == (e.err ? 0 : e.waits + 2), "R4 select cycles",
                        32'(cs_cnt), 32'(e.err ? 0 : e.waits + 2));
                    chk(stb_cnt == (e.err ? 0 : e.waits + 1), "R5 strobe cycles",
                        32'(stb_cnt), 32'(e.err ? 0 : e.waits + 1));
                    if (!e.write && !e.err)
                        chk(rd_data == e.rdata, "R7 read data", 32'(rd_data), 32'(e.rdata));
                end
                cs_cnt = 0; stb_cnt = 0; cs_seen = 4'hF;
            end
            if (mem_cs_n != 4'hF) begin
                cs_cnt++;
                cs_seen = mem_cs_n;
                if (!$onehot(~mem_cs_n)) chk(1'b0, "R9 multiple selects", 32'(mem_cs_n), 0);
            end
            if (!mem_oe_n || !mem_we_n) stb_cnt++;
            if (mem_dout_en != !mem_we_n) chk(1'b0, "R6 drive enable", 32'(mem_dout_en), 32'(!mem_we_n));
            if (mem_we_n && mem_dout != 16'h0) chk(1'b0, "R6 idle data", 32'(mem_dout), 0);
            if (!mem_we_n) mem[mem_addr[9:0]] = mem_dout;
        end
    end

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle bus while in reset
        chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n, "R1 strobes in reset",
            {mem_cs_n, mem_oe_n, mem_we_n}, 6'h3F);
        chk(!done && !mem_dout_en && mem_dout == 16'h0, "R1 outputs in reset",
            {done, mem_dout_en, mem_dout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_cs_n == 4'hF && !done, "R1 idle after reset", {mem_cs_n, done}, 5'h1E);

        one(1'b1, 16'h0010, 16'hA5A5, 0);          // R2 bank 0, R6 write
        one(1'b0, 16'h0010, 16'h0000, 0);          // R7 read back
        one(1'b1, 16'h0800, 16'h1234, 3);          // R2 page 2 is bank 1 (limit exclusive)
        one(1'b0, 16'h07FF, 16'h0000, 7);          // R2 page 1 still bank 0, R4 max waits
        one(1'b0, 16'h0800, 16'h0000, 1);
        one(1'b1, 16'h2FFF, 16'hBEEF, 2);          // R2 last page of bank 3
        one(1'b0, 16'h2FFF, 16'h0000, 5);
        one(1'b0, 16'h3000, 16'h0000, 2);          // R3 first unclaimed page
        one(1'b1, 16'hFC10, 16'hDEAD, 0);          // R3 write ignored
        one(1'b0, 16'h0010, 16'h0000, 0);          // R3 memory still holds A5A5

        // R8: second request arrives while the first is busy
        wait_cfg = 3'd4;
        send(1'b1, 16'h1400, 16'h7777);
        send(1'b0, 16'h1400, 16'h0000);
        drain();
        wait_cfg = 3'd0;
        send(1'b0, 16'h0800, 16'h0000);
        send(1'b1, 16'h0004, 16'h0F0F);
        drain();

        // R2: bank 1 limit equal to bank 0 makes bank 1 empty
        bank_limits = {8'd12, 8'd9, 8'd2, 8'd2};
        one(1'b0, 16'h0800, 16'h0000, 1);
        bank_limits = {8'd12, 8'd9, 8'd5, 8'd2};

        for (int k = 0; k < 24; k++) begin
            logic [15:0] a;
            a = 16'($urandom_range(0, 16'h33FF));
            one(1'($urandom_range(0, 1)), a, 16'($urandom), int'($urandom_range(0, 7)));
        end

        chk(exp_q.size() == 0, "R8 all completed", 32'(exp_q.size()), 0);
        report();
    end
endmodule